// File: doc/BRIEF.md
# Sigma-Delta Sinc Decimator with Result Integrator

This block turns a one-bit sigma-delta bitstream into signed multi-bit conversion results. Each accepted bit is mapped to +1 or -1 and passed through a sinc filter of programmable order that decimates by the filter ratio FOSR. Consecutive filter outputs are then summed in groups of IOSR by an integrator stage, and each group total becomes one conversion result. Besides plain sinc orders 1 to 5, a fast mode is available. It runs a second-order sinc with double gain and a longer settling period.

A conversion is armed by setting the enable and pulsing the start input. The order, both ratio fields and the continuous bit are captured at that moment. The block then produces either one result or a steady stream of results, one every FOSR*IOSR input bits. Results appear in a holding register with an end-of-conversion flag, and a sticky overrun flag reports results that overwrote unread ones. The bit input is a valid-qualified stream with an implied ready that is always high. A modulator strobe cannot be stalled, so there is no back-pressure. A consumer that falls behind is reported through the overrun flag and is never throttled.

Top module: `sinc_decimator`

## Requirements
- R1: The ratio fields hold the ratio minus one: `fosr_field` = FOSR-1 (FOSR 1..1024) and `iosr_field` = IOSR-1 (IOSR 1..256). A field of zero gives a ratio of 1.
- R2: `ord_sel` = 0 selects fast mode. Values 1..5 select a sinc filter of that order, and values 6 and 7 behave as order 5.
- R3: A conversion begins only on a cycle where `flt_en` is 1 and `sw_start` is 1. A start pulse while `flt_en` is 0 has no effect, and so does an enable without a start pulse.
- R4: For sinc order p, the first result is published on the input bit numbered FOSR*(IOSR-1+p)+p after the start, counting accepted bits from 1. It is visible one clock after that bit is accepted.
- R5: In fast mode, the first result is published on input bit FOSR*(IOSR+3)+2 after the start.
- R6: Bits map 1 to +1 and 0 to -1. A result is the sum of IOSR consecutive outputs of the sinc^p filter over those values, and fast mode doubles the value. A constant-1 input therefore yields FOSR^p*IOSR, or 2*FOSR^2*IOSR in fast mode, and a constant-0 input yields the negative. Arithmetic wraps modulo 2^32.
- R7: With `cont_mode` = 0 at start, exactly one result is produced and the filter then stops.
- R8: With `cont_mode` = 1 at start, a further result is produced every FOSR*IOSR input bits after the first one.
- R9: `res_ready` goes to 1 when a result is published. A one-cycle `res_read` pulse clears it, unless a new result is published in that same cycle.
- R10: `ovr_flag` goes to 1 when a result is published while `res_ready` is 1 and no `res_read` is given. It then stays 1 until a `ovr_clear` pulse arrives, and `res_read` does not clear it.
- R11: Clearing `flt_en` stops the conversion and resets all filter and integrator state. A later start converts as if the block were fresh.
- R12: Order, ratio fields and continuous bit are sampled at start. Changing them during a conversion has no effect on that conversion.
- R13: `res_data` holds its value between published results.
- R14: After reset `res_ready`, `ovr_flag` and `res_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_valid | input | 1 | Bitstream strobe; one input bit is taken per cycle with it high |
| sd_bit | input | 1 | Bitstream value, 1 = +1, 0 = -1 |
| flt_en | input | 1 | Filter enable; 0 stops and clears the filter |
| sw_start | input | 1 | Start pulse |
| cont_mode | input | 1 | 1 = continuous results, 0 = single result |
| ord_sel | input | 3 | 0 = fast mode, 1..5 = sinc order |
| fosr_field | input | 10 | Filter ratio minus one |
| iosr_field | input | 8 | Integrator ratio minus one |
| res_read | input | 1 | Result read pulse, clears the end-of-conversion flag |
| ovr_clear | input | 1 | Overrun clear pulse |
| res_ready | output | 1 | End-of-conversion flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| res_data | output | 32 | Signed result register |

## Verification
The checker watches the flag protocol on every cycle. It confirms that the end-of-conversion flag is set by each published result and cleared by a read, that overrun is raised, held and released by the right pulses, that the result register holds steady between results, and that nothing is published while the enable is low. The numeric behaviour needs the bench's scenarios: the exact bit on which each result lands for every order, the filtered value against a convolution model, the full-scale gains, single and continuous stopping, and the immunity to mid-conversion field changes. Only the bench's directed runs can show that a restart after disabling carries no stale filter state.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int MAX_STAGES = 5;

  // Number of sinc stages used, which is also the number of settling bits
  // dropped after a start.
  function automatic logic [2:0] stage_count(input logic [2:0] o);
    if (o == 3'd0) return 3'd2;
    if (o > 3'd5)  return 3'd5;
    return o;
  endfunction

  // Decimated outputs needed before the first valid filter value.
  function automatic logic [2:0] warm_count(input logic [2:0] o);
    return (o == 3'd0) ? 3'd4 : stage_count(o);
  endfunction
endpackage

// File: rtl/sdf_integ_chain.sv
module sdf_integ_chain #(
  parameter int DW  = 32,
  parameter int NST = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [DW-1:0] x,
  input  logic [2:0]           sel,
  output logic signed [DW-1:0] y
);
  logic signed [DW-1:0] st_q [NST];
  logic signed [DW-1:0] st_d [NST];

  // Zero-delay cascade: every stage sees the updated value of the one before.
  genvar k;
  generate
    for (k = 0; k < NST; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign st_d[k] = st_q[k] + x;
      end else begin : g_next
        assign st_d[k] = st_q[k] + st_d[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) st_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NST; i++) st_q[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < NST; i++) st_q[i] <= st_d[i];
    end
  end

  always_comb begin
    y = st_d[0];
    for (int i = 0; i < NST; i++)
      if (sel == 3'(i + 1)) y = st_d[i];
  end
endmodule

// File: rtl/sdf_comb_chain.sv
module sdf_comb_chain #(
  parameter int DW  = 32,
  parameter int NST = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [DW-1:0] din,
  input  logic [2:0]           sel,
  output logic signed [DW-1:0] y
);
  logic signed [DW-1:0] z_q [NST];
  logic signed [DW-1:0] d   [NST];
  logic signed [DW-1:0] src [NST];

  genvar k;
  generate
    for (k = 0; k < NST; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign src[k] = din;
      end else begin : g_next
        assign src[k] = d[k-1];
      end
      assign d[k] = src[k] - z_q[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) z_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NST; i++) z_q[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < NST; i++) z_q[i] <= src[i];
    end
  end

  always_comb begin
    y = d[0];
    for (int i = 0; i < NST; i++)
      if (sel == 3'(i + 1)) y = d[i];
  end
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int FOSR_W = 10,
  parameter int IOSR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              in_valid,
  input  logic              cont_in,
  input  logic [2:0]        ord_in,
  input  logic [FOSR_W-1:0] fosr_in,
  input  logic [IOSR_W-1:0] iosr_in,
  output logic              clr,
  output logic              samp_step,
  output logic              dec_step,
  output logic              acc_en,
  output logic              last,
  output logic [2:0]        stages,
  output logic              fast
);
  logic              run_q, cont_q;
  logic [2:0]        ord_q, skip_q, warm_q;
  logic [FOSR_W-1:0] fosr_q, phase_q;
  logic [IOSR_W-1:0] iosr_q, icnt_q;
  logic              start_go, take;

  assign start_go  = enable & start & ~run_q;
  assign take      = run_q & enable & in_valid;
  assign samp_step = take & (skip_q == 3'd0);
  assign dec_step  = samp_step & (phase_q == fosr_q);
  assign acc_en    = dec_step & (warm_q == 3'd0);
  assign last      = acc_en & (icnt_q == iosr_q);
  assign clr       = start_go | ~enable;
  assign stages    = stage_count(ord_q);
  assign fast      = (ord_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cont_q  <= 1'b0;
      ord_q   <= '0;
      fosr_q  <= '0;
      iosr_q  <= '0;
      skip_q  <= '0;
      warm_q  <= '0;
      phase_q <= '0;
      icnt_q  <= '0;
    end else if (!enable) begin
      run_q   <= 1'b0;
      skip_q  <= '0;
      warm_q  <= '0;
      phase_q <= '0;
      icnt_q  <= '0;
    end else if (start_go) begin
      run_q   <= 1'b1;
      cont_q  <= cont_in;
      ord_q   <= ord_in;
      fosr_q  <= fosr_in;
      iosr_q  <= iosr_in;
      skip_q  <= stage_count(ord_in);
      warm_q  <= 3'(warm_count(ord_in) - 3'd1);
      phase_q <= '0;
      icnt_q  <= '0;
    end else begin
      if (take && skip_q != 3'd0) skip_q <= skip_q - 3'd1;
      if (samp_step) phase_q <= (phase_q == fosr_q) ? '0 : phase_q + 1'b1;
      if (dec_step && warm_q != 3'd0) warm_q <= warm_q - 3'd1;
      if (acc_en) icnt_q <= (icnt_q == iosr_q) ? '0 : icnt_q + 1'b1;
      if (last && !cont_q) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdf_result.sv
module sdf_result #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 acc_en,
  input  logic                 last,
  input  logic                 fast,
  input  logic signed [DW-1:0] y,
  input  logic                 rd,
  input  logic                 ovr_clr,
  output logic signed [DW-1:0] result,
  output logic                 eoc,
  output logic                 ovr
);
  logic signed [DW-1:0] acc_q, scaled, sum;

  assign scaled = fast ? (y <<< 1) : y;
  assign sum    = acc_q + scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
      eoc    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (clr)         acc_q <= '0;
      else if (acc_en) acc_q <= last ? '0 : sum;

      if (last) result <= sum;

      if (last)    eoc <= 1'b1;
      else if (rd) eoc <= 1'b0;

      if (last && eoc && !rd) ovr <= 1'b1;
      else if (ovr_clr)       ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sdf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FOSR_W = 10,
  parameter int IOSR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_valid,
  input  logic              sd_bit,
  input  logic              flt_en,
  input  logic              sw_start,
  input  logic              cont_mode,
  input  logic [2:0]        ord_sel,
  input  logic [FOSR_W-1:0] fosr_field,
  input  logic [IOSR_W-1:0] iosr_field,
  input  logic              res_read,
  input  logic              ovr_clear,
  output logic              res_ready,
  output logic              ovr_flag,
  output logic [DW-1:0]     res_data
);
  logic                 clr, samp_step, dec_step, acc_en, res_fire, fast;
  logic [2:0]           stages;
  logic signed [DW-1:0] x_val, integ_y, comb_y, res_s;

  assign x_val    = sd_bit ? DW'(1) : -DW'(1);
  assign res_data = res_s;

  sdf_ctrl #(.FOSR_W(FOSR_W), .IOSR_W(IOSR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(flt_en), .start(sw_start),
    .in_valid(sd_valid), .cont_in(cont_mode), .ord_in(ord_sel),
    .fosr_in(fosr_field), .iosr_in(iosr_field), .clr(clr),
    .samp_step(samp_step), .dec_step(dec_step), .acc_en(acc_en),
    .last(res_fire), .stages(stages), .fast(fast)
  );

  sdf_integ_chain #(.DW(DW), .NST(MAX_STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(samp_step),
    .x(x_val), .sel(stages), .y(integ_y)
  );

  sdf_comb_chain #(.DW(DW), .NST(MAX_STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(dec_step),
    .din(integ_y), .sel(stages), .y(comb_y)
  );

  sdf_result #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en), .last(res_fire),
    .fast(fast), .y(comb_y), .rd(res_read), .ovr_clr(ovr_clear),
    .result(res_s), .eoc(res_ready), .ovr(ovr_flag)
  );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flt_en,
  input logic          res_read,
  input logic          ovr_clear,
  input logic          res_fire,
  input logic          res_ready,
  input logic          ovr_flag,
  input logic [DW-1:0] res_data
);
  a_r9_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire |=> res_ready);
  a_r9_eoc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    res_read && !res_fire |=> !res_ready);
  a_r10_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire && res_ready && !res_read |=> ovr_flag);
  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clear |=> ovr_flag);
  a_r10_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clear && !res_fire |=> !ovr_flag);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_fire |=> $stable(res_data));
  a_r11_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |=> !res_fire);
endmodule

bind sinc_decimator sdf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_en(flt_en), .res_read(res_read),
  .ovr_clear(ovr_clear), .res_fire(res_fire), .res_ready(res_ready),
  .ovr_flag(ovr_flag), .res_data(res_data)
);

// File: tb/sinc_decimator_test.sv
module sinc_decimator_test;
  logic clk = 0, rst_n = 0;
  logic sd_valid = 0, sd_bit = 0, flt_en = 0, sw_start = 0, cont_mode = 0;
  logic [2:0] ord_sel = 0;
  logic [9:0] fosr_field = 0;
  logic [7:0] iosr_field = 0;
  logic res_read = 0, ovr_clear = 0;
  logic res_ready, ovr_flag;
  logic [31:0] res_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string ctx = "";
  int bits_q [0:4095];
  int h [0:127];
  int hn [0:127];
  int hlen;
  int cur_s, cur_w, cur_g, cur_F, cur_I;
  longint last_val;

  sinc_decimator uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, ctx, act, exp);
    end
  endtask

  function automatic void build_h(input int q, input int F);
    for (int t = 0; t < 128; t++) h[t] = 0;
    h[0] = 1; hlen = 1;
    for (int r = 0; r < q; r++) begin
      for (int t = 0; t < hlen + F - 1; t++) begin
        hn[t] = 0;
        for (int u = 0; u < F; u++)
          if (t - u >= 0 && t - u < hlen) hn[t] += h[t-u];
      end
      hlen += F - 1;
      for (int t = 0; t < hlen; t++) h[t] = hn[t];
    end
  endfunction

  function automatic int exp_idx(input int k);
    return cur_s + cur_F * (cur_w + (k + 1) * cur_I - 1);
  endfunction

  function automatic longint exp_val(input int k);
    longint acc = 0;
    for (int m = cur_w + k * cur_I; m < cur_w + (k + 1) * cur_I; m++)
      for (int t = 0; t < hlen; t++) begin
        int j = cur_F * m - 1 - t;
        if (j >= 0) acc += longint'(h[t]) * (bits_q[cur_s + j] != 0 ? 1 : -1);
      end
    return cur_g * acc;
  endfunction

  task automatic pulse_start();
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic feed(input int b);
    @(negedge clk); sd_valid = 1; sd_bit = b[0];
    @(negedge clk); sd_valid = 0;
  endtask

  task automatic stop_filter();
    @(negedge clk); flt_en = 0;
    @(negedge clk);
  endtask

  // pat: 0 random, 1 all ones, 2 all zeros; scr: rewrite fields after start
  task automatic run_conv(input int ordv, input int F, input int I, input int c,
                          input int nres, input int pat, input int scr);
    int q, nfeed, kseen;
    longint e;
    q = (ordv == 0) ? 2 : (ordv > 5 ? 5 : ordv);
    cur_s = q; cur_w = (ordv == 0) ? 4 : q; cur_g = (ordv == 0) ? 2 : 1;
    cur_F = F; cur_I = I;
    build_h(q, F);
    @(negedge clk);
    ord_sel = ordv[2:0]; fosr_field = 10'(F - 1); iosr_field = 8'(I - 1);
    cont_mode = c[0]; flt_en = 1;
    pulse_start();
    if (scr != 0) begin
      ord_sel = 3'($urandom_range(0, 5));
      fosr_field = 10'($urandom_range(0, 20));
      iosr_field = 8'($urandom_range(0, 5));
      cont_mode = ~cont_mode;
    end
    nfeed = (c != 0) ? exp_idx(nres - 1) : exp_idx(0) + F * I + 3;
    kseen = 0;
    for (int n = 1; n <= nfeed; n++) begin
      int b;
      b = (pat == 1) ? 1 : (pat == 2) ? 0 : int'($urandom_range(0, 1));
      bits_q[n-1] = b;
      feed(b);
      if (res_ready) begin
        if (ordv == 0) chk(n == exp_idx(kseen), "R5 latency", n, exp_idx(kseen));
        else           chk(n == exp_idx(kseen), "R4 latency", n, exp_idx(kseen));
        e = exp_val(kseen);
        chk(longint'($signed(res_data)) == e, "R6 value", longint'($signed(res_data)), e);
        last_val = longint'($signed(res_data));
        kseen++;
        res_read = 1;
        @(negedge clk); res_read = 0;
        chk(!res_ready, "R9 read clears", res_ready, 0);
        chk(longint'($signed(res_data)) == e, "R13 hold", longint'($signed(res_data)), e);
      end
      repeat ($urandom_range(0, 1)) @(negedge clk);
    end
    if (c != 0) chk(kseen == nres, "R8 result count", kseen, nres);
    else        chk(kseen == 1, "R7 single result", kseen, 1);
    stop_filter();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    ctx = "reset";
    chk(res_ready == 0, "R14 eoc", res_ready, 0);
    chk(ovr_flag == 0, "R14 ovr", ovr_flag, 0);
    chk(res_data == 0, "R14 data", res_data, 0);
    rst_n = 1;

    ctx = "ratio one";      run_conv(1, 1, 1, 0, 1, 0, 0);   // R1
    ctx = "sinc3";          run_conv(3, 4, 2, 0, 1, 0, 0);   // R2
    ctx = "fast";           run_conv(0, 5, 3, 0, 1, 0, 0);   // R2 R5
    ctx = "full scale";     run_conv(4, 4, 3, 0, 1, 1, 0);
    chk(last_val == 768, "R6 full scale", last_val, 768);
    ctx = "fast neg scale"; run_conv(0, 4, 2, 0, 1, 2, 0);
    chk(last_val == -64, "R6 fast scale", last_val, -64);
    ctx = "sinc5 cont";     run_conv(5, 3, 2, 1, 3, 0, 0);   // R8
    ctx = "order7";         run_conv(7, 2, 2, 0, 1, 1, 0);
    chk(last_val == 64, "R2 clamp", last_val, 64);
    ctx = "scrambled";      run_conv(3, 4, 2, 0, 1, 0, 1);   // R12
    ctx = "scrambled cont"; run_conv(2, 3, 2, 1, 2, 0, 1);   // R12

    for (int r = 0; r < 8; r++) begin
      int o, f, i, c;
      o = $urandom_range(0, 7); f = $urandom_range(1, 8); i = $urandom_range(1, 4);
      c = $urandom_range(0, 1);
      if (f * i < 2) c = 0;
      $sformat(ctx, "random %0d o%0d f%0d i%0d c%0d", r, o, f, i, c);
      run_conv(o, f, i, c, 3, 0, 0);
    end

    // R10: overrun with unread results, order 1, FOSR 2, IOSR 1, continuous
    ctx = "overrun";
    cur_s = 1; cur_w = 1; cur_g = 1; cur_F = 2; cur_I = 1; build_h(1, 2);
    @(negedge clk); ord_sel = 1; fosr_field = 1; iosr_field = 0; cont_mode = 1; flt_en = 1;
    pulse_start();
    for (int n = 1; n <= 5; n++) begin
      bits_q[n-1] = (n % 2);
      feed(n % 2);
      if (n == 3) chk(res_ready && !ovr_flag, "R10 first no ovr", ovr_flag, 0);
    end
    chk(ovr_flag == 1, "R10 ovr set", ovr_flag, 1);
    chk(longint'($signed(res_data)) == exp_val(1), "R10 newest kept",
        longint'($signed(res_data)), exp_val(1));
    @(negedge clk); res_read = 1;
    @(negedge clk); res_read = 0;
    chk(ovr_flag == 1, "R10 read keeps ovr", ovr_flag, 1);
    chk(res_ready == 0, "R9 cleared", res_ready, 0);
    @(negedge clk); ovr_clear = 1;
    @(negedge clk); ovr_clear = 0;
    chk(ovr_flag == 0, "R10 ovr cleared", ovr_flag, 0);
    stop_filter();

    // R11: drop enable mid-conversion, then restart fresh
    ctx = "enable drop";
    @(negedge clk); ord_sel = 3; fosr_field = 3; iosr_field = 1; cont_mode = 0; flt_en = 1;
    pulse_start();
    for (int n = 0; n < 12; n++) feed(1);
    stop_filter();
    for (int n = 0; n < 40; n++) feed(int'($urandom_range(0, 1)));
    chk(res_ready == 0, "R11 no result when off", res_ready, 0);
    run_conv(3, 4, 2, 0, 1, 0, 0);

    // R3: start without enable, enable without start
    ctx = "no start";
    @(negedge clk); flt_en = 0; ord_sel = 1; fosr_field = 0; iosr_field = 0;
    pulse_start();
    for (int n = 0; n < 20; n++) feed(1);
    chk(res_ready == 0, "R3 start ignored while disabled", res_ready, 0);
    @(negedge clk); flt_en = 1;
    for (int n = 0; n < 20; n++) feed(1);
    chk(res_ready == 0, "R3 enable alone idle", res_ready, 0);
    stop_filter();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule